// File: doc/BRIEF.md
# Multi-channel PWM with shadowed updates

This block is a bank of pulse-width modulators behind a simple register port. Each channel owns one 32-bit control word that holds an enable, a self-clearing update request, a frequency increment and a duty threshold. A phase accumulator adds the active increment on every clock. The output is driven high while the top eight accumulator bits exceed the active threshold. The output frequency is therefore the clock rate times the increment divided by two to the power of the increment width. The period is set by a fractional step rather than by a terminal count.

Software writes new settings into the staged copy and raises the update request. The staged increment and threshold reach the generator only at the next accumulator wrap, which is the start of an output cycle. At that same edge the request clears. While a request is pending, every write to that channel is dropped whole, so a half-applied configuration never reaches the generator. Clearing the enable parks the channel: its output goes low and its accumulator is held at zero. Enabling it again restarts the cycle from zero and commits any pending request at once.

Channels are picked by the address bits above bit 10, so each channel sits in its own 1 KiB window with its register at offset zero.

Top module: `pwm_bank`

## Requirements
- R1: After reset every control word reads as zero and every channel output is low.
- R2: Control word encoding: bit 31 is enable, bit 30 is update request, bits [8 +: INC_W] are the increment, and bits [7:0] are the threshold. All other bits read as zero. A read strobe returns the staged word on `rdData` after the following clock edge.
- R3: The channel index is `addr[ADDR_W-1:10]`. The register sits only at `addr[9:0] == 0`. A write to any other offset, or to an index of NUM_CH or above, changes no channel. A read from such an address returns zero.
- R4: While a channel runs, its accumulator advances by the active increment modulo 2^INC_W each cycle. In the first sampled cycle after the enable is taken up, the accumulator is zero.
- R5: A running channel's output is high exactly when the top eight accumulator bits are greater than the active threshold. A threshold of 255 therefore never drives it high.
- R6: A staged write with the update bit clear does not change the output. Setting the update bit commits the staged increment and threshold at the next accumulator wrap and clears the update bit at that same edge.
- R7: A write that reaches a channel while its update bit is set is discarded completely. This includes a write presented in the very cycle in which the commit happens.
- R8: With the enable clear, the output is low and the accumulator is held at zero from the second edge after the write onward. When enable is set with the update bit, the commit happens on the next edge, without waiting for a wrap.
- R9: An active increment of zero leaves the accumulator at zero, so the output stays low for every threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address; the channel window is picked by the bits above 10 |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, registered on a read strobe |
| pwmOut | output | NUM_CH | Channel outputs |

## Verification
A software write and the hardware commit can land on the same clock edge. At that edge the update bit is still set, so the write must be dropped even though the request is being cleared. The bench restarts a channel from a known zero phase and counts cycles to the exact wrap edge. It stages an update earlier in that period and presents a second write so that it is captured on the wrap edge. It then reads back the word and expects the earlier fields with the update bit clear. A write one cycle later must be accepted.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int ENA_BIT   = 31;
  localparam int UPD_BIT   = 30;
  localparam int THR_W     = 8;
  localparam int INC_LSB   = 8;
  localparam int WIN_BITS  = 10;

  // control -> datapath strobes
  typedef struct packed {
    logic run;
    logic commit;
  } ctlStrb_t;

  // datapath -> control status
  typedef struct packed {
    logic wrap;
    logic idle;
  } dpStat_t;
endpackage

// File: rtl/pwm_chan_ctl.sv
module pwm_chan_ctl
  import pwm_bank_pkg::*;
#(
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrHit,
  input  logic             wrEna,
  input  logic             wrUpd,
  input  logic [INC_W-1:0] wrInc,
  input  logic [THR_W-1:0] wrThr,
  input  dpStat_t          stat,
  output ctlStrb_t         strb,
  output logic             enaQ,
  output logic             updReq,
  output logic [INC_W-1:0] incStg,
  output logic [THR_W-1:0] thrStg
);
  logic wrTake;
  logic commit;

  assign wrTake = wrHit && !updReq;
  assign commit = updReq && (stat.wrap || stat.idle);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enaQ   <= 1'b0;
      updReq <= 1'b0;
      incStg <= '0;
      thrStg <= '0;
    end else if (wrTake) begin
      enaQ   <= wrEna;
      updReq <= wrUpd;
      incStg <= wrInc;
      thrStg <= wrThr;
    end else if (commit) begin
      updReq <= 1'b0;
    end
  end

  assign strb.run    = enaQ;
  assign strb.commit = commit;

  // R7: a write against a pending request leaves every staged field untouched
  assert_discard_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && updReq) |=> ($stable(incStg) && $stable(thrStg) && $stable(enaQ)));

  // R6: the request only clears at a cycle boundary or while parked
  assert_pending_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (updReq && !stat.wrap && !stat.idle) |=> updReq);
endmodule

// File: rtl/pwm_chan_dp.sv
module pwm_chan_dp
  import pwm_bank_pkg::*;
#(
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  logic [INC_W-1:0] incStg,
  input  logic [THR_W-1:0] thrStg,
  output dpStat_t          stat,
  output logic             pwmOut
);
  logic [INC_W-1:0] acc;
  logic [INC_W-1:0] incAct;
  logic [THR_W-1:0] thrAct;
  logic             runQ;
  logic [INC_W:0]   sum;
  logic [THR_W-1:0] phaseTop;

  assign sum      = {1'b0, acc} + {1'b0, incAct};
  assign phaseTop = acc[INC_W-1 -: THR_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      incAct <= '0;
      thrAct <= '0;
      runQ   <= 1'b0;
    end else begin
      runQ <= strb.run;
      if (!strb.run || !runQ) acc <= '0;
      else                    acc <= sum[INC_W-1:0];
      if (strb.commit) begin
        incAct <= incStg;
        thrAct <= thrStg;
      end
    end
  end

  assign stat.wrap = runQ && strb.run && sum[INC_W];
  assign stat.idle = !runQ;
  assign pwmOut    = runQ && (phaseTop > thrAct);

  // R8: a parked channel is low with a zero phase on the next cycle
  assert_parked_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (!pwmOut && acc == '0));

  // R6: active settings only move on a commit strobe
  assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(thrAct) && $stable(incAct)));

  // R5: the largest threshold never produces a high output
  assert_max_thr_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    pwmOut |-> (thrAct != '1));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int INC_W  = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  localparam int CH_IDX_W = ADDR_W - WIN_BITS;

  logic [CH_IDX_W-1:0] chIdx;
  logic                offOk;
  logic [NUM_CH-1:0]   wrHit;
  logic [NUM_CH-1:0]   rdHit;
  logic [31:0]         chWord [NUM_CH];
  logic [31:0]         rdMux;

  assign chIdx = addr[ADDR_W-1:WIN_BITS];
  assign offOk = (addr[WIN_BITS-1:0] == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ctlStrb_t         strb;
    dpStat_t          stat;
    logic             enaQ;
    logic             updReq;
    logic [INC_W-1:0] incStg;
    logic [THR_W-1:0] thrStg;

    assign rdHit[c] = offOk && (chIdx == CH_IDX_W'(c));
    assign wrHit[c] = wrEn && rdHit[c];

    pwm_chan_ctl #(.INC_W(INC_W)) u_ctl (
      .clk    (clk),
      .rstN   (rstN),
      .wrHit  (wrHit[c]),
      .wrEna  (wrData[ENA_BIT]),
      .wrUpd  (wrData[UPD_BIT]),
      .wrInc  (wrData[INC_LSB +: INC_W]),
      .wrThr  (wrData[THR_W-1:0]),
      .stat   (stat),
      .strb   (strb),
      .enaQ   (enaQ),
      .updReq (updReq),
      .incStg (incStg),
      .thrStg (thrStg)
    );

    pwm_chan_dp #(.INC_W(INC_W)) u_dp (
      .clk    (clk),
      .rstN   (rstN),
      .strb   (strb),
      .incStg (incStg),
      .thrStg (thrStg),
      .stat   (stat),
      .pwmOut (pwmOut[c])
    );

    always_comb begin
      chWord[c]                   = '0;
      chWord[c][ENA_BIT]          = enaQ;
      chWord[c][UPD_BIT]          = updReq;
      chWord[c][INC_LSB +: INC_W] = incStg;
      chWord[c][THR_W-1:0]        = thrStg;
    end
  end

  always_comb begin
    rdMux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rdHit[c]) rdMux = chWord[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdMux;
  end

  // R3: at most one channel is selected by any write
  assert_onehot_wr_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrHit));

  // R1: outputs are low in the first cycle after reset
  assert_reset_low_R1: assert property (@(posedge clk)
    !rstN |=> (pwmOut == '0 && rdData == '0));
endmodule

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 2;
  localparam int IW   = 10;
  localparam int AW   = 12;
  localparam int MODV = 1 << IW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [NCH-1:0] pwmOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  pwm_bank #(.NUM_CH(NCH), .INC_W(IW), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mkWord(input bit en, input bit upd,
                                         input int inc, input int thr);
    logic [31:0] w;
    w = '0;
    w[31] = en;
    w[30] = upd;
    w[8 +: IW] = inc[IW-1:0];
    w[7:0] = thr[7:0];
    return w;
  endfunction

  function automatic bit expOut(input int j, input int inc, input int thr);
    return (((j * inc) % MODV) / (MODV / 256)) > thr;
  endfunction

  function automatic int highPerPeriod(input int inc, input int thr);
    int n;
    n = 0;
    for (int k = 0; k < MODV / inc; k++) if (expOut(k, inc, thr)) n++;
    return n;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int off, input logic [31:0] d);
    addr = AW'((ch << 10) | off);
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int ch, input int off, output logic [31:0] q);
    addr = AW'((ch << 10) | off);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    q = rdData;
  endtask

  // Park the channel, then enable with an update. Returns at phase j=0.
  task automatic startRun(input int ch, input int inc, input int thr);
    wr(ch, 0, mkWord(0, 0, 0, 0));
    @(negedge clk);
    wr(ch, 0, mkWord(1, 1, inc, thr));
    @(negedge clk);
  endtask

  task automatic runSeq(input int ch, input int inc, input int thr, input int n);
    startRun(ch, inc, thr);
    for (int j = 0; j < n; j++) begin
      check(pwmOut[ch] == expOut(j, inc, thr), $sformatf("R4/R5 ch%0d inc=%0d thr=%0d j=%0d", ch, inc, thr, j),
            32'(pwmOut[ch]), 32'(expOut(j, inc, thr)));
      @(negedge clk);
    end
  endtask

  task automatic countHigh(input int ch, input int n, output int cnt);
    cnt = 0;
    for (int j = 0; j < n; j++) begin
      if (pwmOut[ch]) cnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    int cnt;
    int polls;
    int incs [7] = '{3, 32, 64, 128, 512, 1000, 1023};
    int thrs [8] = '{0, 1, 64, 127, 128, 200, 254, 255};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(pwmOut == '0, "R1 outputs low", 32'(pwmOut), 0);
    rd(0, 0, q); check(q == 0, "R1 ch0 word", q, 0);
    rd(1, 0, q); check(q == 0, "R1 ch1 word", q, 0);

    // R2 encoding: pad bits are dropped
    wr(1, 0, 32'h3FFF_FFA5);
    rd(1, 0, q); check(q == 32'h0003_FFA5, "R2 field layout", q, 32'h0003_FFA5);

    // R3 decode
    wr(0, 0, mkWord(0, 0, 77, 12));
    wr(0, 4, mkWord(1, 0, 5, 5));
    rd(0, 0, q); check(q == mkWord(0, 0, 77, 12), "R3 bad offset write ignored", q, mkWord(0, 0, 77, 12));
    rd(0, 4, q); check(q == 0, "R3 bad offset reads zero", q, 0);
    wr(2, 0, mkWord(1, 0, 9, 9));
    rd(0, 0, q); check(q == mkWord(0, 0, 77, 12), "R3 out-of-range index ch0", q, mkWord(0, 0, 77, 12));
    rd(1, 0, q); check(q == 32'h0003_FFA5, "R3 out-of-range index ch1", q, 32'h0003_FFA5);
    rd(2, 0, q); check(q == 0, "R3 out-of-range read zero", q, 0);

    // R4/R5 sweep on ch0, independent ch1 stays parked and low
    foreach (incs[a]) foreach (thrs[b]) runSeq(0, incs[a], thrs[b], 40);
    check(pwmOut[1] == 1'b0, "R3 ch1 untouched by ch0", 32'(pwmOut[1]), 0);
    runSeq(1, 64, 100, 40);

    // R9 zero increment
    runSeq(0, 0, 0, 40);

    // R8 disable forces low, immediate commit on enable
    runSeq(0, 64, 0, 20);
    wr(0, 0, mkWord(0, 0, 64, 0));
    @(negedge clk);
    countHigh(0, 32, cnt); check(cnt == 0, "R8 parked output low", cnt, 0);
    wr(0, 0, mkWord(1, 1, 64, 50));
    rd(0, 0, q); check(q[30] == 1'b1, "R8 request seen before commit", 32'(q[30]), 1);
    rd(0, 0, q); check(q == mkWord(1, 0, 64, 50), "R8 commit on enable", q, mkWord(1, 0, 64, 50));

    // R6 staged write without update does not reach the output
    startRun(0, 64, 100);
    wr(0, 0, mkWord(1, 0, 64, 200));
    countHigh(0, 32, cnt);
    check(cnt == 2 * highPerPeriod(64, 100), "R6 staged not live", cnt, 2 * highPerPeriod(64, 100));
    wr(0, 0, mkWord(1, 1, 64, 200));
    polls = 0;
    do begin rd(0, 0, q); polls++; end while (q[30] && polls < 40);
    check(polls <= 17, "R6 commit within one period", polls, 17);
    check(q == mkWord(1, 0, 64, 200), "R6 committed word", q, mkWord(1, 0, 64, 200));
    @(negedge clk);
    countHigh(0, 32, cnt);
    check(cnt == 2 * highPerPeriod(64, 200), "R6 new duty live", cnt, 2 * highPerPeriod(64, 200));

    // R7 discard while pending and on the commit edge itself
    startRun(0, 64, 100);                  // j=0
    repeat (5) @(negedge clk);             // j=5
    wr(0, 0, mkWord(1, 1, 64, 30));        // taken, j=6
    wr(0, 0, mkWord(0, 0, 5, 7));          // discarded, j=7
    rd(0, 0, q);                           // j=8
    check(q == mkWord(1, 1, 64, 30), "R7 pending write discarded", q, mkWord(1, 1, 64, 30));
    check(pwmOut[0] == expOut(8, 64, 100), "R7 output still old thr", 32'(pwmOut[0]), 32'(expOut(8, 64, 100)));
    repeat (7) @(negedge clk);             // j=15
    wr(0, 0, mkWord(1, 1, 64, 250));       // lands on commit edge, j=16
    check(pwmOut[0] == expOut(16, 64, 30), "R6 new thr after wrap", 32'(pwmOut[0]), 32'(expOut(16, 64, 30)));
    rd(0, 0, q);                           // j=17
    check(q == mkWord(1, 0, 64, 30), "R7 same-cycle write discarded", q, mkWord(1, 0, 64, 30));
    wr(0, 0, mkWord(1, 0, 64, 250));
    rd(0, 0, q);
    check(q == mkWord(1, 0, 64, 250), "R7 write after commit taken", q, mkWord(1, 0, 64, 250));

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule